// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects single-cycle event strobes from a network controller's transmit path, receive path, bus error logic and general timer. Each event sets a sticky bit in a status register. Software clears a bit by writing a 1 to it. A mask register picks which of these bits can reach one level-sensitive interrupt line.

The causes fall into two groups: normal causes and abnormal causes. Each group is ORed into a summary bit, and each summary bit has its own enable. An abnormal cause raises the line only when three things are set: its own status bit, its own enable, and the abnormal-summary enable.

Two causes come from state that the block tracks itself rather than from an incoming strobe:
- A receive-buffer-lost event fires when a buffer-available level goes from high to low.
- An early-receive event fires when the byte count of the current frame rises above a programmable threshold.

Top module: `irq_status_ctrl`

## Requirements
- R1: Writing a 1 in bit i of `wr_data` while `sts_wr` is high clears status bit i (i in 0..7) on the next clock edge.
- R2: Writing a 0 in bit i of `wr_data` while `sts_wr` is high leaves status bit i unchanged.
- R3: If an event and a clear of the same status bit fall in one cycle, the bit stays set.
- R4: Status bits 0..4 are normal causes. Bit 0 is transmit done and bit 1 is receive done. Status bit 8 is their normal summary: it is high when any of bits 0..4 is high together with the same-numbered mask bit. The interrupt is asserted by this summary only when mask bit 8 is also set. With mask bits 8 and 9 both clear, `irq_o` stays low.
- R5: Status bits 5..7 are abnormal causes: 5 is transmit underflow, 6 is receive buffer lost, and 7 is bus error. Status bit 9 is their summary. An abnormal cause drives `irq_o` only when its status bit, its own mask bit and mask bit 9 are all set.
- R6: Status bit 6 is set only on a high-to-low change of `rx_buf_avail`. It is not set while `rx_buf_avail` has stayed low since reset.
- R7: Status bit 3 (early receive) is set when `rx_byte_cnt` first becomes strictly greater than the threshold written through `thr_wr`. It fires once per crossing. A threshold of 0 disables it.
- R8: A `ev_tx_loaded` strobe sets status bit 2 (transmit early) only if mask bit 2 is set in that cycle.
- R9: A `ev_timer` strobe sets status bit 4.
- R10: Summary bits 8 and 9, and `irq_o`, follow the current status and mask in every cycle. Clearing every contributing bit drops them.
- R11: After reset, the status, the mask, the threshold and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_done | input | 1 | Transmit-done strobe |
| ev_rx_done | input | 1 | Receive-done strobe |
| ev_tx_loaded | input | 1 | Frame fully moved into the transmit FIFO |
| ev_timer | input | 1 | General timer expired strobe |
| ev_tx_underflow | input | 1 | Transmit FIFO underflow strobe |
| ev_bus_err | input | 1 | Bus error strobe |
| rx_buf_avail | input | 1 | Level: a receive buffer is available |
| rx_byte_cnt | input | CNT_W | Bytes moved for the current received frame |
| sts_wr | input | 1 | Write-1-to-clear strobe for the status register |
| msk_wr | input | 1 | Write strobe for the mask register |
| thr_wr | input | 1 | Write strobe for the early-receive threshold |
| wr_data | input | DATA_W | Write data shared by the three write strobes |
| status_o | output | 10 | Status readback, summaries in bits 8 and 9 |
| mask_o | output | 10 | Mask readback |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
The following rules are checked on every cycle:
- The write-1-to-clear behaviour, and set winning over clear.
- That `irq_o` stays low with both summary enables off, and that it is forced high by a fully enabled abnormal cause.
- That no summary bit is set without a cause behind it.
- That the edge-derived bits (buffer lost, early receive, transmit early) only rise after a qualifying input.

Only the bench scenarios can show the absence of a flag after reset while no buffer exists, the strict greater-than comparison at the threshold, the single firing per crossing, and the threshold-zero disable. These depend on input histories.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NORM_W  = 5;
  localparam int ABN_W   = 3;
  localparam int CAUSE_W = NORM_W + ABN_W;
  localparam int REG_W   = CAUSE_W + 2;

  // cause positions (software-visible encoding)
  localparam int B_TX_DONE  = 0;
  localparam int B_RX_DONE  = 1;
  localparam int B_TX_EARLY = 2;
  localparam int B_RX_EARLY = 3;
  localparam int B_TIMER    = 4;
  localparam int B_TX_UFLOW = 5;
  localparam int B_BUF_LOST = 6;
  localparam int B_BUS_ERR  = 7;
  localparam int B_NSUM     = 8;
  localparam int B_ASUM     = 9;

  // threshold compare: zero threshold disables, strict greater-than
  function automatic logic early_hit(input logic [31:0] cnt, input logic [31:0] thr);
    return (thr != 32'd0) && (cnt > thr);
  endfunction

  // any status bit that is also enabled
  function automatic logic any_masked(input logic [CAUSE_W-1:0] st,
                                      input logic [CAUSE_W-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/irq_edge_events.sv
module irq_edge_events #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_buf_avail,
  input  logic [CNT_W-1:0] rx_byte_cnt,
  input  logic [CNT_W-1:0] thresh,
  output logic             buf_lost_o,
  output logic             early_o
);
  import irq_stat_pkg::*;

  logic avail_q;
  logic hit_q;
  logic hit_now;

  assign hit_now    = early_hit(32'(rx_byte_cnt), 32'(thresh));
  assign buf_lost_o = avail_q & ~rx_buf_avail;
  assign early_o    = hit_now & ~hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      avail_q <= rx_buf_avail;
      hit_q   <= hit_now;
    end
  end
endmodule

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    logic clr_hit;
    assign clr_hit = clr_en & clr_i[i];
    always_ff @(posedge clk) begin
      if (rst)           bit_q <= 1'b0;
      else if (set_i[i]) bit_q <= 1'b1;
      else if (clr_hit)  bit_q <= 1'b0;
    end
    assign stat_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary (
  input  logic [irq_stat_pkg::CAUSE_W-1:0] stat_i,
  input  logic [irq_stat_pkg::REG_W-1:0]   mask_i,
  output logic                             norm_sum_o,
  output logic                             abn_sum_o,
  output logic                             irq_o
);
  import irq_stat_pkg::*;

  logic [CAUSE_W-1:0] norm_sel;
  logic [CAUSE_W-1:0] abn_sel;

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_sel
    if (i < NORM_W) begin : g_norm
      assign norm_sel[i] = mask_i[i];
      assign abn_sel[i]  = 1'b0;
    end else begin : g_abn
      assign norm_sel[i] = 1'b0;
      assign abn_sel[i]  = mask_i[i];
    end
  end

  assign norm_sum_o = any_masked(stat_i, norm_sel);
  assign abn_sum_o  = any_masked(stat_i, abn_sel);
  assign irq_o      = (norm_sum_o & mask_i[B_NSUM]) | (abn_sum_o & mask_i[B_ASUM]);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ev_tx_done,
  input  logic                           ev_rx_done,
  input  logic                           ev_tx_loaded,
  input  logic                           ev_timer,
  input  logic                           ev_tx_underflow,
  input  logic                           ev_bus_err,
  input  logic                           rx_buf_avail,
  input  logic [CNT_W-1:0]               rx_byte_cnt,
  input  logic                           sts_wr,
  input  logic                           msk_wr,
  input  logic                           thr_wr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [irq_stat_pkg::REG_W-1:0] status_o,
  output logic [irq_stat_pkg::REG_W-1:0] mask_o,
  output logic                           irq_o
);
  import irq_stat_pkg::*;

  logic [REG_W-1:0]   mask_q;
  logic [CNT_W-1:0]   thr_q;
  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] stat_q;
  logic               buf_lost_ev;
  logic               early_ev;
  logic               tx_early_ev;
  logic               norm_sum;
  logic               abn_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      thr_q  <= '0;
    end else begin
      if (msk_wr) mask_q <= wr_data[REG_W-1:0];
      if (thr_wr) thr_q  <= wr_data[CNT_W-1:0];
    end
  end

  irq_edge_events #(.CNT_W(CNT_W)) u_edges (
    .clk          (clk),
    .rst          (rst),
    .rx_buf_avail (rx_buf_avail),
    .rx_byte_cnt  (rx_byte_cnt),
    .thresh       (thr_q),
    .buf_lost_o   (buf_lost_ev),
    .early_o      (early_ev)
  );

  assign tx_early_ev = ev_tx_loaded & mask_q[B_TX_EARLY];

  always_comb begin
    set_vec             = '0;
    set_vec[B_TX_DONE]  = ev_tx_done;
    set_vec[B_RX_DONE]  = ev_rx_done;
    set_vec[B_TX_EARLY] = tx_early_ev;
    set_vec[B_RX_EARLY] = early_ev;
    set_vec[B_TIMER]    = ev_timer;
    set_vec[B_TX_UFLOW] = ev_tx_underflow;
    set_vec[B_BUF_LOST] = buf_lost_ev;
    set_vec[B_BUS_ERR]  = ev_bus_err;
  end

  irq_w1c_bank #(.W(CAUSE_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .clr_en (sts_wr),
    .clr_i  (wr_data[CAUSE_W-1:0]),
    .stat_o (stat_q)
  );

  irq_summary u_sum (
    .stat_i     (stat_q),
    .mask_i     (mask_q),
    .norm_sum_o (norm_sum),
    .abn_sum_o  (abn_sum),
    .irq_o      (irq_o)
  );

  assign status_o = {abn_sum, norm_sum, stat_q};
  assign mask_o   = mask_q;
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_rx_done,
  input logic              ev_tx_done,
  input logic              ev_tx_loaded,
  input logic              rx_buf_avail,
  input logic [CNT_W-1:0]  rx_byte_cnt,
  input logic              sts_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [9:0]        status_o,
  input logic [9:0]        mask_o,
  input logic              irq_o
);
  a_r1_clear_one: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && wr_data[0] && !ev_tx_done) |=> !status_o[0]);
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && !wr_data[0] && status_o[0]) |=> status_o[0]);
  a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_done && sts_wr && wr_data[1]) |=> status_o[1]);
  a_r4_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
    (!mask_o[8] && !mask_o[9]) |-> !irq_o);
  a_r5_abn_path: assert property (@(posedge clk) disable iff (rst)
    (status_o[5] && mask_o[5] && mask_o[9]) |-> irq_o);
  a_r6_lost_after_drop: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[6]) |-> !$past(rx_buf_avail));
  a_r7_early_needs_bytes: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[3]) |-> ($past(rx_byte_cnt) != '0));
  a_r8_txearly_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[2]) |-> ($past(mask_o[2]) && $past(ev_tx_loaded)));
  a_r10_abn_sum_cause: assert property (@(posedge clk) disable iff (rst)
    (status_o[7:5] == 3'b000) |-> !status_o[9]);
  a_r10_norm_sum_cause: assert property (@(posedge clk) disable iff (rst)
    (status_o[4:0] == 5'b00000) |-> !status_o[8]);
endmodule

bind irq_status_ctrl irq_status_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_rx_done   (ev_rx_done),
  .ev_tx_done   (ev_tx_done),
  .ev_tx_loaded (ev_tx_loaded),
  .rx_buf_avail (rx_buf_avail),
  .rx_byte_cnt  (rx_byte_cnt),
  .sts_wr       (sts_wr),
  .wr_data      (wr_data),
  .status_o     (status_o),
  .mask_o       (mask_o),
  .irq_o        (irq_o)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_tx_loaded = 0, ev_timer = 0;
  logic ev_tx_underflow = 0, ev_bus_err = 0, rx_buf_avail = 0;
  logic [CNT_W-1:0]  rx_byte_cnt = '0;
  logic sts_wr = 0, msk_wr = 0, thr_wr = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [9:0] status_o, mask_o;
  logic irq_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  irq_status_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (.*);

  typedef struct {
    logic [9:0] st;
    logic [9:0] mk;
    logic       irq;
    string      tag;
  } item_t;
  item_t sb_q[$];

  // reference state, built from the requirements
  logic [7:0]       m_stat = '0;
  logic [9:0]       m_mask = '0;
  logic [CNT_W-1:0] m_thr  = '0;
  logic             m_avail = 0;
  logic             m_hit   = 0;

  task automatic tick(input string tag);
    logic [7:0] ev;
    logic hit, ns, as;
    item_t it;
    hit = (m_thr != 0) && (rx_byte_cnt > m_thr);
    ev = '0;
    ev[0] = ev_tx_done;
    ev[1] = ev_rx_done;
    ev[2] = ev_tx_loaded && m_mask[2];
    ev[3] = hit && !m_hit;
    ev[4] = ev_timer;
    ev[5] = ev_tx_underflow;
    ev[6] = m_avail && !rx_buf_avail;
    ev[7] = ev_bus_err;
    m_hit   = hit;
    m_avail = rx_buf_avail;
    if (sts_wr) m_stat = m_stat & ~wr_data[7:0];
    m_stat = m_stat | ev;
    if (msk_wr) m_mask = wr_data[9:0];
    if (thr_wr) m_thr  = wr_data[CNT_W-1:0];
    ns = (m_stat[4:0] & m_mask[4:0]) != 0;
    as = (m_stat[7:5] & m_mask[7:5]) != 0;
    it.st  = {as, ns, m_stat};
    it.mk  = m_mask;
    it.irq = (ns && m_mask[8]) || (as && m_mask[9]);
    it.tag = tag;
    @(posedge clk);
    sb_q.push_back(it);
    #1;
    ev_tx_done = 0; ev_rx_done = 0; ev_tx_loaded = 0; ev_timer = 0;
    ev_tx_underflow = 0; ev_bus_err = 0;
    sts_wr = 0; msk_wr = 0; thr_wr = 0; wr_data = '0;
  endtask

  always @(negedge clk) begin
    if (!rst && sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (status_o !== it.st || mask_o !== it.mk || irq_o !== it.irq) begin
        n_fail++;
        $display("FAIL %s: status=%h mask=%h irq=%b expected status=%h mask=%h irq=%b",
                 it.tag, status_o, mask_o, irq_o, it.st, it.mk, it.irq);
      end
    end
  end

  task automatic wmask(input logic [9:0] v, input string tag);
    msk_wr = 1; wr_data = DATA_W'(v); tick(tag);
  endtask
  task automatic wclr(input logic [9:0] v, input string tag);
    sts_wr = 1; wr_data = DATA_W'(v); tick(tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    n_checks++;
    if (status_o !== '0 || mask_o !== '0 || irq_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: status=%h mask=%h irq=%b expected all zero", status_o, mask_o, irq_o);
    end
    #2;
    // R6: low since reset must not flag
    tick("R6 idle no buffer");
    ev_tx_done = 1; tick("R4 set without enable");
    wmask(10'h101, "R4 normal enable raises irq");
    wclr(10'h000, "R2 zero write keeps bit");
    wclr(10'h001, "R1 R10 clear drops summary and irq");
    ev_rx_done = 1; tick("R3 prep");
    ev_rx_done = 1; sts_wr = 1; wr_data = 16'h0002; tick("R3 set beats clear");
    wclr(10'h0FF, "R1 clear all");
    ev_timer = 1; tick("R9 timer bit");
    wmask(10'h000, "R4 no enable, irq low");
    wclr(10'h010, "R1 clear timer");
    ev_tx_underflow = 1; wmask(10'h020, "R5 own enable only");
    wmask(10'h200, "R5 summary enable only");
    wmask(10'h220, "R5 both enables raise irq");
    wclr(10'h020, "R10 abnormal cleared");
    rx_buf_avail = 1; tick("R6 buffer present");
    rx_buf_avail = 0; tick("R6 buffer lost flagged");
    tick("R6 single flag");
    wclr(10'h040, "R1 clear lost");
    rx_byte_cnt = 12'd500; tick("R7 zero threshold disabled");
    rx_byte_cnt = 12'd0; thr_wr = 1; wr_data = 16'd100; tick("R7 set threshold");
    rx_byte_cnt = 12'd50; tick("R7 below threshold");
    rx_byte_cnt = 12'd100; tick("R7 equal is not above");
    rx_byte_cnt = 12'd101; tick("R7 crossing sets bit");
    wclr(10'h008, "R7 clear early");
    rx_byte_cnt = 12'd150; tick("R7 no refire while above");
    rx_byte_cnt = 12'd0; tick("R7 frame over");
    rx_byte_cnt = 12'd200; tick("R7 new crossing");
    ev_tx_loaded = 1; wmask(10'h000, "R8 loaded with enable off");
    wclr(10'h0FF, "R1 clear");
    ev_tx_loaded = 1; tick("R8 disabled no bit");
    wmask(10'h104, "R8 enable tx early");
    ev_tx_loaded = 1; tick("R8 enabled sets bit and irq");
    wmask(10'h380, "R5 bus error path enable");
    ev_bus_err = 1; tick("R5 bus error irq");
    ev_timer = 1; sts_wr = 1; wr_data = 16'h0084; tick("R10 partial clear");
    wclr(10'h0FF, "R10 all clear summaries drop");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule